// File: doc/BRIEF.md
# PWM-to-LED Dimming Translator

This block turns a slow brightness PWM signal into the two controls of a bank of LED current sources: an amplitude code for a current-setting DAC and an enable gate that switches the current on and off. It runs from a fast system clock. It samples the brightness input through a synchronizer and measures the period and high time of each input cycle by counting samples. From the measured duty it computes the new control word, which takes effect at a rising edge of the brightness input. Its outputs therefore follow the frequency and phase of that input.

Two dimming methods are offered, chosen by a static mode input. In amplitude mode the current is held on continuously and its level tracks the duty. This holds down to a floor of one eighth of full scale. Below that floor the level stays at the floor value and the current is chopped within each input period, so the average keeps falling. In pulse mode the level is always full scale and the gate follows the input's high time. In both modes the duty is clamped to a minimum of about 1%, which gives a 100:1 range. When the input has no rising edge for a timeout interval, the outputs fall to zero if the input is low and go to full scale if it is high.

Top module: `pwm_dim_xlate`

## Requirements
- R1: While reset is asserted and after its release until the first update, `amp_o` is 0 and `en_o` is 0.
- R2: The period P is the number of clock cycles between two detected rising edges and H is the number of those cycles with the input high. The duty code is q = floor(H*256/P). The result for one input period takes effect at the rising edge that follows the next one, so there is one period of latency.
- R3: With `mode_i` = 0 (amplitude) and q >= 32, `en_o` stays high continuously and `amp_o` = min(q, 255).
- R4: With `mode_i` = 0 and q < 32, `amp_o` = 32 and `en_o` is high for 8*H cycles once per period, starting just after the rising edge.
- R5: A duty code q < 3 is treated as the 1% floor. The gate on-time is then floor(3*P/32) cycles in amplitude mode and floor(3*P/256) cycles in pulse mode.
- R6: With `mode_i` = 1 (pulse), `amp_o` = 255 whenever updated, and `en_o` is high for H cycles per period, starting just after the rising edge.
- R7: If no rising edge is seen for TIMEOUT cycles while the input is low, `amp_o` becomes 0 and `en_o` becomes 0.
- R8: If no rising edge is seen for TIMEOUT cycles while the input is high, `amp_o` becomes 255 and `en_o` stays high, in either mode.
- R9: `amp_o` changes only at an update on a rising edge or at a timeout. Between these events it holds its value.
- R10: `mode_i` selects the method (0 amplitude, 1 pulse). It is sampled at each update and is meant to stay static.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the brightness PWM |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| brt_i | input | 1 | Brightness PWM input, asynchronous to clk |
| mode_i | input | 1 | Dimming method: 0 amplitude, 1 pulse |
| amp_o | output | CODE_W (8) | Current amplitude code, 255 is full scale |
| en_o | output | 1 | Current enable gate |

## Verification
The bench builds the block with a 12-bit period counter, a 600-cycle timeout and the default 8-bit amplitude code. With these values, input periods of 120 to 200 cycles can be measured many times over in a short run. Both the stuck-low and the stuck-high timeouts are also reached within a few hundred cycles. Because these periods are short, the exact duty codes at the 12.5% floor, just below it and at the 1% clamp can be reached with whole-cycle high times. The one-period update latency can also be observed directly.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;

  typedef enum logic {
    DIM_ANALOG  = 1'b0,
    DIM_DIGITAL = 1'b1
  } dim_mode_e;

  // smallest duty code (out of 2**code_w) that is at least 1%
  function automatic int min_duty_q(input int code_w);
    return ((1 << code_w) + 99) / 100;
  endfunction

endpackage

// File: rtl/pwm_edge_meas.sv
module pwm_edge_meas #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 60000,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brt_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             cap_o,
  output logic             tmo_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] hi_o
);

  localparam logic [CNT_W-1:0] TMO_V = CNT_W'(TIMEOUT);

  logic [SYNC_N-1:0] sync_q;
  logic              lvl_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  hcnt_q, hcnt_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic [CNT_W-1:0]  hi_q, hi_d;
  logic              seen_q, seen_d;
  logic              cap_q, cap_d;
  logic              lvl, rise, sat, tmo;

  assign lvl  = sync_q[SYNC_N-1];
  assign rise = lvl & ~lvl_d_q;
  assign sat  = (cnt_q == TMO_V);
  assign tmo  = ~rise & (cnt_q == TMO_V - 1'b1);

  always_comb begin
    cnt_d  = cnt_q;
    hcnt_d = hcnt_q;
    per_d  = per_q;
    hi_d   = hi_q;
    seen_d = seen_q;
    cap_d  = rise & seen_q;
    if (rise) begin
      per_d  = cnt_q;
      hi_d   = hcnt_q;
      cnt_d  = CNT_W'(1);
      hcnt_d = CNT_W'(1);
      seen_d = 1'b1;
    end else begin
      if (!sat) cnt_d = cnt_q + 1'b1;
      if (!sat && lvl) hcnt_d = hcnt_q + 1'b1;
      if (tmo) seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      lvl_d_q <= 1'b0;
      cnt_q   <= '0;
      hcnt_q  <= '0;
      per_q   <= '0;
      hi_q    <= '0;
      seen_q  <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_N-2:0], brt_i};
      lvl_d_q <= lvl;
      cnt_q   <= cnt_d;
      hcnt_q  <= hcnt_d;
      per_q   <= per_d;
      hi_q    <= hi_d;
      seen_q  <= seen_d;
      cap_q   <= cap_d;
    end
  end

  assign lvl_o  = lvl;
  assign rise_o = rise;
  assign tmo_o  = tmo;
  assign cap_o  = cap_q;
  assign per_o  = per_q;
  assign hi_o   = hi_q;

endmodule

// File: rtl/pwm_duty_div.sv
module pwm_duty_div #(
  parameter int CNT_W = 16,
  parameter int QW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_i,
  input  logic [CNT_W-1:0] den_i,
  output logic [QW-1:0]    q_o,
  output logic             done_o
);

  localparam int SW = $clog2(QW + 1);

  logic [CNT_W:0]   rem_q, rem_d, trial;
  logic [CNT_W-1:0] den_q, den_d;
  logic [QW-1:0]    quo_q, quo_d;
  logic [SW-1:0]    step_q, step_d;
  logic             first_q, first_d;
  logic             done_q, done_d;
  logic             ge;

  // first step compares the raw numerator (bit QW-1), later steps shift
  assign trial = first_q ? rem_q : {rem_q[CNT_W-1:0], 1'b0};
  assign ge    = (trial >= {1'b0, den_q});

  always_comb begin
    rem_d   = rem_q;
    den_d   = den_q;
    quo_d   = quo_q;
    step_d  = step_q;
    first_d = first_q;
    done_d  = 1'b0;
    if (start_i) begin
      rem_d   = {1'b0, num_i};
      den_d   = den_i;
      quo_d   = '0;
      step_d  = SW'(QW);
      first_d = 1'b1;
    end else if (step_q != '0) begin
      rem_d   = ge ? (trial - {1'b0, den_q}) : trial;
      quo_d   = {quo_q[QW-2:0], ge};
      step_d  = step_q - 1'b1;
      first_d = 1'b0;
      done_d  = (step_q == SW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      step_q  <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      den_q   <= den_d;
      quo_q   <= quo_d;
      step_q  <= step_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign q_o    = quo_q;
  assign done_o = done_q;

endmodule

// File: rtl/pwm_dim_map.sv
module pwm_dim_map
  import pwm_dim_pkg::*;
#(
  parameter  int CNT_W  = 16,
  parameter  int CODE_W = 8,
  localparam int QW     = CODE_W + 1,
  localparam int LW     = CNT_W + 3
) (
  input  dim_mode_e         mode_i,
  input  logic [QW-1:0]     q_i,
  input  logic [CNT_W-1:0]  hi_i,
  input  logic [CNT_W-1:0]  per_i,
  output logic [CODE_W-1:0] amp_o,
  output logic              full_o,
  output logic [LW-1:0]     len_o
);

  localparam int             PW      = CNT_W + CODE_W;
  localparam logic [QW-1:0]  FULL_Q  = QW'(2**CODE_W - 1);
  localparam logic [QW-1:0]  FLOOR_Q = QW'(2**(CODE_W-3));
  localparam logic [QW-1:0]  MIN_Q   = QW'(min_duty_q(CODE_W));

  logic [PW-1:0] min_prod;
  logic [LW-1:0] min_dig, min_ana, hi8;
  logic          low;

  assign min_prod = PW'(per_i) * PW'(MIN_Q);
  assign min_dig  = LW'(min_prod >> CODE_W);
  assign min_ana  = LW'(min_prod >> (CODE_W - 3));
  assign hi8      = LW'(hi_i) << 3;
  assign low      = (q_i < MIN_Q);

  always_comb begin
    if (mode_i == DIM_DIGITAL) begin
      amp_o  = '1;
      full_o = 1'b0;
      len_o  = low ? min_dig : LW'(hi_i);
    end else if (q_i >= FLOOR_Q) begin
      amp_o  = (q_i >= FULL_Q) ? '1 : q_i[CODE_W-1:0];
      full_o = 1'b1;
      len_o  = LW'(per_i);
    end else begin
      amp_o  = FLOOR_Q[CODE_W-1:0];
      full_o = 1'b0;
      len_o  = low ? min_ana : hi8;
    end
  end

endmodule

// File: rtl/pwm_dim_gate.sv
module pwm_dim_gate #(
  parameter  int CNT_W  = 16,
  parameter  int CODE_W = 8,
  localparam int LW     = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              apply_i,
  input  logic              tmo_i,
  input  logic              lvl_i,
  input  logic [CODE_W-1:0] amp_i,
  input  logic              full_i,
  input  logic [LW-1:0]     len_i,
  output logic [CODE_W-1:0] amp_o,
  output logic              en_o
);

  logic [CODE_W-1:0] amp_q, amp_d;
  logic              full_q, full_d;
  logic [LW-1:0]     len_q, len_d;
  logic [LW-1:0]     cyc_q, cyc_d;

  always_comb begin
    amp_d  = amp_q;
    full_d = full_q;
    len_d  = len_q;
    cyc_d  = cyc_q;
    if (rise_i) begin
      cyc_d = '0;
    end else if (cyc_q < len_q) begin
      cyc_d = cyc_q + 1'b1;
    end
    if (apply_i) begin
      amp_d  = amp_i;
      full_d = full_i;
      len_d  = len_i;
    end else if (tmo_i) begin
      amp_d  = lvl_i ? '1 : '0;
      full_d = lvl_i;
      len_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q  <= '0;
      full_q <= 1'b0;
      len_q  <= '0;
      cyc_q  <= '0;
    end else begin
      amp_q  <= amp_d;
      full_q <= full_d;
      len_q  <= len_d;
      cyc_q  <= cyc_d;
    end
  end

  assign amp_o = amp_q;
  assign en_o  = full_q | (cyc_q < len_q);

endmodule

// File: rtl/pwm_dim_xlate.sv
module pwm_dim_xlate
  import pwm_dim_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 60000,
  parameter int CODE_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brt_i,
  input  logic              mode_i,
  output logic [CODE_W-1:0] amp_o,
  output logic              en_o
);

  localparam int QW = CODE_W + 1;
  localparam int LW = CNT_W + 3;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              lvl_w, rise_w, cap_w, tmo_w;
  logic [CNT_W-1:0]  per_w, hi_w;
  logic [QW-1:0]     q_w;
  logic              done_w;
  logic              ready_q, ready_d;
  logic              apply_w;
  logic [CODE_W-1:0] map_amp;
  logic              map_full;
  logic [LW-1:0]     map_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pwm_edge_meas #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT), .SYNC_N(SYNC_N)) u_meas (
    .clk(clk), .rst_n(rst_sync_n), .brt_i(brt_i),
    .lvl_o(lvl_w), .rise_o(rise_w), .cap_o(cap_w), .tmo_o(tmo_w),
    .per_o(per_w), .hi_o(hi_w)
  );

  pwm_duty_div #(.CNT_W(CNT_W), .QW(QW)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .start_i(cap_w),
    .num_i(hi_w), .den_i(per_w), .q_o(q_w), .done_o(done_w)
  );

  always_comb begin
    ready_d = ready_q;
    if (done_w)               ready_d = 1'b1;
    else if (rise_w || tmo_w) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ready_q <= 1'b0;
    else             ready_q <= ready_d;
  end

  assign apply_w = rise_w & ready_q;

  pwm_dim_map #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_map (
    .mode_i(dim_mode_e'(mode_i)), .q_i(q_w), .hi_i(hi_w), .per_i(per_w),
    .amp_o(map_amp), .full_o(map_full), .len_o(map_len)
  );

  pwm_dim_gate #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .rise_i(rise_w), .apply_i(apply_w),
    .tmo_i(tmo_w), .lvl_i(lvl_w), .amp_i(map_amp), .full_i(map_full),
    .len_i(map_len), .amp_o(amp_o), .en_o(en_o)
  );

endmodule

// File: rtl/pwm_dim_xlate_chk.sv
module pwm_dim_xlate_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_i,
  input logic [CODE_W-1:0] amp_o,
  input logic              en_o,
  input logic              rise_i,
  input logic              tmo_i
);

  localparam logic [CODE_W-1:0] FULL  = '1;
  localparam logic [CODE_W-1:0] FLOOR = CODE_W'(2**(CODE_W-3));

  // R6: in pulse mode an open gate always carries full-scale current
  assert_dig_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && en_o) |-> (amp_o == FULL));

  // R3: above the floor in amplitude mode the gate never closes
  assert_ana_cont_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && amp_o > FLOOR) |-> en_o);

  // R4: amplitude mode never drives a nonzero level below the floor
  assert_ana_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && amp_o != '0) |-> (amp_o >= FLOOR));

  // R9: level holds between edge updates and timeouts
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_i || tmo_i) |=> $stable(amp_o));

  // R7 and R8: a timeout leaves either a dark or a fully lit output
  assert_tmo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_i |=> ((amp_o == '0 && !en_o) || (amp_o == FULL && en_o)));

endmodule

bind pwm_dim_xlate pwm_dim_xlate_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .amp_o(amp_o),
  .en_o(en_o), .rise_i(rise_w), .tmo_i(tmo_w)
);

// File: tb/pwm_dim_xlate_tb.sv
module pwm_dim_xlate_tb;

  localparam int CNT_W   = 12;
  localparam int TIMEOUT = 600;
  localparam int CODE_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              brt;
  logic              mode;
  logic [CODE_W-1:0] amp;
  logic              en;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwm_dim_xlate #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .brt_i(brt), .mode_i(mode), .amp_o(amp), .en_o(en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int duty_q(input int h, input int p);
    return (h * 256) / p;
  endfunction

  function automatic int exp_amp(input bit m, input int h, input int p);
    int q;
    q = duty_q(h, p);
    if (m) return 255;
    if (q >= 32) return (q > 255) ? 255 : q;
    return 32;
  endfunction

  function automatic int exp_on(input bit m, input int h, input int p);
    int q;
    q = duty_q(h, p);
    if (m) return (q < 3) ? (3 * p) / 256 : h;
    if (q >= 32) return p;
    if (q < 3) return (3 * p) / 32;
    return 8 * h;
  endfunction

  task automatic run_period(input int h, input int p, output int on_cnt, output int amp_mid);
    on_cnt  = 0;
    amp_mid = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (en) on_cnt++;
      if (i == p / 2) amp_mid = int'(amp);
      brt = (i < h);
    end
  endtask

  task automatic t_steady(input string tag, input int h, input int p);
    int on_cnt, amp_mid;
    for (int k = 0; k < 4; k++) run_period(h, p, on_cnt, amp_mid);
    chk({tag, " amp"}, amp_mid, exp_amp(mode, h, p));
    chk({tag, " on"}, on_cnt, exp_on(mode, h, p));
  endtask

  task automatic t_latency();
    int on_cnt, amp_a, amp_b, amp_c;
    for (int k = 0; k < 4; k++) run_period(100, 200, on_cnt, amp_a);
    run_period(150, 200, on_cnt, amp_a);
    run_period(150, 200, on_cnt, amp_b);
    run_period(150, 200, on_cnt, amp_c);
    chk("R2 latency old value", amp_b, 128);
    chk("R2 latency new value", amp_c, 192);
  endtask

  task automatic t_timeout_low();
    int amp_early;
    amp_early = 0;
    for (int i = 0; i < 620; i++) begin
      @(negedge clk);
      if (i == 100) amp_early = int'(amp);
      brt = 1'b0;
    end
    chk("R9 held before timeout", amp_early, 192);
    chk("R7 dark amp", int'(amp), 0);
    chk("R7 dark gate", int'(en), 0);
  endtask

  task automatic t_timeout_high();
    int on_cnt;
    on_cnt = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (i >= 650 && en) on_cnt++;
      brt = 1'b1;
    end
    chk("R8 stuck-high amp", int'(amp), 255);
    chk("R8 stuck-high gate", on_cnt, 50);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    brt   = 1'b0;
    mode  = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 amp in reset", int'(amp), 0);
    chk("R1 gate in reset", int'(en), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 amp after release", int'(amp), 0);
    chk("R1 gate after release", int'(en), 0);

    // amplitude mode (R10: mode 0)
    t_steady("R3 half duty", 100, 200);
    t_steady("R3 three-quarter duty", 150, 200);
    t_steady("R3 near full", 119, 120);
    t_steady("R3 at floor", 25, 200);
    t_steady("R4 below floor", 24, 200);
    t_steady("R4 deep chop", 10, 200);
    t_steady("R5 clamp amplitude", 1, 200);
    t_latency();
    t_timeout_low();

    // pulse mode, switched while dark
    mode = 1'b1;
    t_steady("R6 R10 half duty", 100, 200);
    t_steady("R6 short pulse", 30, 200);
    t_steady("R5 clamp pulse", 1, 200);
    t_timeout_high();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule